// File: doc/BRIEF.md
# Serial-Programmed DAC Control Front End

This block is the digital front end of an 8-bit voltage DAC that is programmed over a three-wire serial link. The link has a serial clock, a data line and an active-low select. All three lines are resampled in the faster system clock domain through synchronizers. The block detects the edges there and shifts data in on each serial clock rise while the select is low. The frame is 16 bits long and is sent MSB first: a control byte, then a data byte.

Nothing in a frame takes effect until the select rises. At that point a frame that holds at least 16 bits is decoded and applied. The control bits act independently of each other: one requests power-down or power-up, one enables loading the data byte, and a reserved bit must be zero. The block holds the 8-bit code and a shutdown flag, which stands for the reference being disconnected. While the block is shut down, the effective code presented to the ladder reads zero and the held code is kept. A sticky error flag records any command that was rejected.

Top module: `serdac_ctrl`

## Requirements
- R1: After reset, the held code, the effective code, the shutdown flag and the error flag are all zero.
- R2: Serial clock or data activity while the select is high changes no output.
- R3: Bits enter MSB first. Word bits [15:13] are spare, bit 12 requests power-down, bit 11 enables loading, bit 10 is reserved, bits 9 and 8 form the pattern check, and bits [7:0] are the data, with bit 0 shifted in last.
- R4: A frame sent as two bytes with a pause between them, with the select held low throughout, behaves exactly like an unbroken frame.
- R5: If the select rises after fewer than 16 bits, the frame is dropped. No output changes, including the error flag.
- R6: If more than 16 bits arrive, only the last 16 bits shifted in are decoded.
- R7: A valid command with bit 11 = 1 loads bits [7:0] into the held code. With bit 11 = 0, the held code is unchanged.
- R8: A valid command with bit 12 = 1 sets shutdown, which forces the effective code to zero and keeps the held code. With bit 12 = 0, shutdown clears and the effective code equals the held code again.
- R9: A valid command with bits 12 and 11 both set powers down and loads the new code in the same commit. Bit 12 = 0 with bit 11 = 1 loads and wakes.
- R10: A command whose bits 9 and 8 are not 0 and 1 changes neither the held code nor the shutdown flag, and sets the error flag. The error flag stays set until reset.
- R11: A command with bit 10 = 1 changes neither the held code nor the shutdown flag, and sets the error flag.
- R12: Bits [15:13] have no effect on the outcome of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| din_i | input | 1 | Serial data |
| cs_ni | input | 1 | Active-low frame select |
| dac_code_o | output | 8 | Held DAC code |
| shutdown_o | output | 1 | Powered down; reference disconnected |
| eff_code_o | output | 8 | Code applied to the ladder, zero while shut down |
| cmd_err_o | output | 1 | Sticky flag for a rejected command |

## Verification
A load and a power-down can fall in the same commit cycle. They then change the held code and the shutdown flag together. The bench provokes this with a frame that has both bit 12 and bit 11 set. It passes only if, after the select rises, the held code shows the new data while the effective code reads zero at the same sampling point. A second frame then loads again and wakes, and the effective code must show the newest data with no intermediate zero left over.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int CODE_W  = 8;
  localparam int FRAME_W = 16;

  // Field order matters: shifted in MSB first.
  typedef struct packed {
    logic [2:0]        spare;
    logic              pd_req;
    logic              load_en;
    logic              rsv;
    logic              pat_hi;
    logic              pat_lo;
    logic [CODE_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg[i] <= RST_VAL;
      else         stg[i] <= stg[i-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               din_s_i,
  input  logic               cs_n_s_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic             sclk_q, cs_q;
  logic             sclk_rise, cs_rise, cs_fall, shift_en;
  logic [CNT_W-1:0] cnt;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign cs_rise   = cs_n_s_i & ~cs_q;
  assign cs_fall   = ~cs_n_s_i & cs_q;
  assign shift_en  = sclk_rise & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_n_s_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       frame_o <= '0;
    else if (shift_en) frame_o <= {frame_o[FRAME_W-2:0], din_s_i};

  // Saturating bit count, restarted at frame start
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)
      cnt <= '0;
    else if (cs_fall)
      cnt <= shift_en ? CNT_W'(1) : '0;
    else if (shift_en && cnt != CNT_W'(FRAME_W))
      cnt <= cnt + 1'b1;

  assign frame_vld_o = cs_rise && (cnt == CNT_W'(FRAME_W));

  AST_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && cs_n_s_i) |=> $stable(frame_o)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(FRAME_W)); // R6
  AST_COMMIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> ($past(cs_n_s_i) == 1'b0)); // R5
endmodule

// File: rtl/serdac_exec.sv
module serdac_exec
  import serdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  cmd_word_t         cmd_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_o,
  output logic              err_o
);
  logic cmd_ok;

  assign cmd_ok = !cmd_i.rsv && !cmd_i.pat_hi && cmd_i.pat_lo;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_o <= '0;
      pd_o   <= 1'b0;
      err_o  <= 1'b0;
    end else if (frame_vld_i) begin
      if (cmd_ok) begin
        if (cmd_i.load_en) code_o <= cmd_i.data;
        pd_o <= cmd_i.pd_req;
      end else begin
        err_o <= 1'b1;
      end
    end

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> ($stable(code_o) && $stable(pd_o))); // R7
  AST_BAD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (cmd_i.rsv || cmd_i.pat_hi || !cmd_i.pat_lo))
      |=> ($stable(code_o) && $stable(pd_o) && err_o)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              cs_ni,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              shutdown_o,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              cmd_err_o
);
  logic [2:0]         pins_s;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame;
  cmd_word_t          cmd;

  // {sclk, din, cs_n}; cs_n resets high
  serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, din_i, cs_ni}),
    .q_o    (pins_s)
  );

  serdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (pins_s[2]),
    .din_s_i     (pins_s[1]),
    .cs_n_s_i    (pins_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  assign cmd = cmd_word_t'(frame);

  serdac_exec u_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .cmd_i       (cmd),
    .code_o      (dac_code_o),
    .pd_o        (shutdown_o),
    .err_o       (cmd_err_o)
  );

  assign eff_code_o = shutdown_o ? '0 : dac_code_o;

  AST_PD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> (eff_code_o == '0)); // R8
  AST_WAKE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutdown_o) |-> (eff_code_o == dac_code_o)); // R8
endmodule

// File: tb/serdac_ctrl_bench.sv
module serdac_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, din = 1'b0, cs_n = 1'b1;
  logic [7:0] code, eff;
  logic       pd, err;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  localparam int HALF = 4; // system clocks per serial clock phase

  always #10 clk = ~clk;

  serdac_ctrl u_serdac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .din_i(din), .cs_ni(cs_n),
    .dac_code_o(code), .shutdown_o(pd), .eff_code_o(eff), .cmd_err_o(err)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, int e_code, bit e_pd, bit e_err);
    chk(code == 8'(e_code), req, code, e_code);
    chk(pd == e_pd, req, pd, e_pd);
    chk(eff == (e_pd ? 8'h00 : 8'(e_code)), req, eff, e_pd ? 0 : e_code);
    chk(err == e_err, req, err, e_err);
  endtask

  task automatic shift_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = w[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(logic [31:0] w, int n);
    cs_n = 1'b0;
    wait_clk(HALF);
    shift_bits(w, n);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
  endtask

  task automatic t_reset();
    expect_out("R1", 0, 0, 0);
  endtask

  task automatic t_load();
    frame(32'h0980, 16);
    expect_out("R3 R7", 8'h80, 0, 0);
    frame(32'hE9A5, 16);
    expect_out("R12", 8'hA5, 0, 0);
    frame(32'h013C, 16);
    expect_out("R7 no load", 8'hA5, 0, 0);
  endtask

  task automatic t_split();
    cs_n = 1'b0;
    wait_clk(HALF);
    shift_bits(32'h09, 8);
    wait_clk(40);
    shift_bits(32'h5A, 8);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
    expect_out("R4", 8'h5A, 0, 0);
  endtask

  task automatic t_short_long();
    frame(32'h0911, 12);
    expect_out("R5", 8'h5A, 0, 0);
    frame(32'hFF0933, 24);
    expect_out("R6", 8'h33, 0, 0);
  endtask

  task automatic t_cs_high();
    for (int i = 0; i < 20; i++) begin
      din = i[0] ^ i[2];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(10);
    expect_out("R2", 8'h33, 0, 0);
  endtask

  task automatic t_power();
    frame(32'h11FF, 16);
    expect_out("R8 down", 8'h33, 1, 0);
    frame(32'h0100, 16);
    expect_out("R8 wake", 8'h33, 0, 0);
    frame(32'h1977, 16);
    expect_out("R9 down+load", 8'h77, 1, 0);
    frame(32'h0944, 16);
    expect_out("R9 load+wake", 8'h44, 0, 0);
  endtask

  task automatic t_bad();
    frame(32'h0B12, 16);
    expect_out("R10 pattern", 8'h44, 0, 1);
    frame(32'h1812, 16);
    expect_out("R10 sticky", 8'h44, 0, 1);
    do_reset();
    expect_out("R1 after reset", 0, 0, 0);
    frame(32'h1D99, 16);
    expect_out("R11", 0, 0, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_load();
    t_split();
    t_short_long();
    t_cs_high();
    t_power();
    t_bad();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule